// File: doc/BRIEF.md
# Accumulator ALU and Page Branch Unit

This block is the data-manipulation stage of a small 8-bit register-oriented processor. In one step it takes an operation code, the current accumulator and carry flag, and one operand byte. It returns the next accumulator value and the next carry flag. The operand byte has already been read by the memory sequencer, either through the data-pointer register or through the program counter. For a short branch the same operand byte is the target. The block evaluates the branch condition and gives the next low byte of the program counter. It also gives a flag that tells the register file to carry into the high byte.

The operation code is a 4-bit value `n_code`. Bit 3 selects the immediate form of an ALU operation, where the operand is taken at the program counter. For a branch, bit 3 inverts the sense of the test. Bits 2:0 choose the operation or the test. The results are registered, so every output reflects the inputs that were present at the previous rising clock edge. The register file and memory sequencing are outside this block.

Top module: `accbr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are cleared to zero on that edge.
- R2: ALU code with bits 2:0 = 0 (load) gives `d_out` = operand and leaves `df_out` equal to `df_in`.
- R3: ALU codes with bits 2:0 = 1, 2, 3 give D OR operand, D AND operand and D XOR operand, and leave `df_out` equal to `df_in`.
- R4: ALU code with bits 2:0 = 4 (add) gives `d_out` = low 8 bits of D + operand, and `df_out` = the carry out of bit 7.
- R5: ALU code with bits 2:0 = 5 gives operand minus D. Code 7 gives D minus operand. Both are formed by two's-complement addition, with `df_out` = 1 when no borrow occurs and 0 when a borrow occurs.
- R6: ALU code with bits 2:0 = 6 (shift right) gives `d_out` = D >> 1 with bit 7 = 0 and `df_out` = old D bit 0. The operand has no effect.
- R7: In an ALU operation, `n_code[3]` = 1 sets `imm_src` = 1 and advances the program counter low byte by one: `pc_lo_out` = `pc_lo_in`+1, and `pc_hi_inc` = 1 when `pc_lo_in` = FF. With `n_code[3]` = 0, `imm_src` = 0, `pc_lo_out` = `pc_lo_in` and `pc_hi_inc` = 0. An ALU operation never sets `br_taken`.
- R8: The branch test is picked by `n_code[2:0]` and inverted by `n_code[3]`. Code 0 is always true. Code 2 tests D = 0. Code 3 tests DF = 1. Codes 4 to 7 test `ext_flag[0]` to `ext_flag[3]` high. Codes 1 and 9 are never taken, and so is code 8.
- R9: A taken branch gives `pc_lo_out` = operand and `pc_hi_inc` = 0. A branch that is not taken gives `pc_lo_out` = `pc_lo_in`+1, with `pc_hi_inc` = 1 only when `pc_lo_in` = FF.
- R10: A branch (`is_branch` = 1) leaves `d_out` = `d_in` and `df_out` = `df_in`, and gives `imm_src` = 0.
- R11: Outputs change one clock after the inputs are applied and reflect only the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| is_branch | input | 1 | 1 = short branch, 0 = ALU operation |
| n_code | input | 4 | Operation or test code |
| opnd | input | 8 | Operand byte or branch target byte |
| d_in | input | 8 | Current accumulator |
| df_in | input | 1 | Current carry flag |
| ext_flag | input | 4 | External test flags |
| pc_lo_in | input | 8 | Current program counter low byte |
| d_out | output | 8 | Next accumulator |
| df_out | output | 1 | Next carry flag |
| br_taken | output | 1 | Branch condition met |
| pc_lo_out | output | 8 | Next program counter low byte |
| pc_hi_inc | output | 1 | Carry into program counter high byte |
| imm_src | output | 1 | Operand was taken at the program counter |

## Verification
Addition is tried once with a sum that overflows and once with a sum that does not, which shows whether the carry is really taken from bit 8. Both subtract directions are tried with a borrow, with no borrow and with equal values, which separates the two operand orders and shows the borrow polarity. Each branch test is tried with its condition both met and not met, in both senses, and with an all-ones program counter byte. This shows whether a taken target or a carry into the high byte is produced. Shift and logic operations are given a carry flag that differs from their result, so a stray write to the flag can be seen.

// File: rtl/accbr_pkg.sv
package accbr_pkg;
    localparam int DATA_W = 8;
    localparam int FLAG_N = 4;
    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_OR   = 3'd1,
        OP_AND  = 3'd2,
        OP_XOR  = 3'd3,
        OP_ADD  = 3'd4,
        OP_SUBR = 3'd5,   // operand minus accumulator
        OP_SHR  = 3'd6,
        OP_SUBL = 3'd7    // accumulator minus operand
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] d;
        logic              df;
    } acc_t;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic              hi_inc;
    } pc_step_t;

    // An operation changes the carry flag only for add, subtract and shift.
    function automatic logic writes_flag(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUBR) || (op == OP_SUBL) || (op == OP_SHR);
    endfunction
endpackage

// File: rtl/accbr_alu.sv
module accbr_alu
    import accbr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  alu_op_e        op,
    input  logic [DW-1:0]  opnd,
    input  logic [DW-1:0]  d_cur,
    input  logic           df_cur,
    output logic [DW-1:0]  d_nxt,
    output logic           df_nxt
);
    logic [DW-1:0] add_a, add_b;
    logic          add_cin;
    logic [DW:0]   sum;

    // One shared adder: subtraction inverts one side and adds one.
    always_comb begin
        add_a   = d_cur;
        add_b   = opnd;
        add_cin = 1'b0;
        if (op == OP_SUBR) begin
            add_a   = opnd;
            add_b   = ~d_cur;
            add_cin = 1'b1;
        end else if (op == OP_SUBL) begin
            add_a   = d_cur;
            add_b   = ~opnd;
            add_cin = 1'b1;
        end
        sum = {1'b0, add_a} + {1'b0, add_b} + {{DW{1'b0}}, add_cin};
    end

    always_comb begin
        d_nxt  = d_cur;
        df_nxt = df_cur;
        unique case (op)
            OP_LOAD: d_nxt = opnd;
            OP_OR:   d_nxt = d_cur | opnd;
            OP_AND:  d_nxt = d_cur & opnd;
            OP_XOR:  d_nxt = d_cur ^ opnd;
            OP_SHR: begin
                d_nxt  = {1'b0, d_cur[DW-1:1]};
                df_nxt = d_cur[0];
            end
            default: begin
                d_nxt  = sum[DW-1:0];
                df_nxt = sum[DW];
            end
        endcase
    end
endmodule

// File: rtl/accbr_cond.sv
module accbr_cond
    import accbr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FN = FLAG_N
) (
    input  logic [CODE_W-1:0] code,
    input  logic [DW-1:0]     d_cur,
    input  logic              df_cur,
    input  logic [FN-1:0]     flags,
    output logic              taken
);
    localparam int FIDX_W = (FN > 1) ? $clog2(FN) : 1;

    logic base;
    logic reserved;
    logic [FIDX_W-1:0] fidx;

    assign fidx     = code[FIDX_W-1:0];
    assign reserved = (code[2:0] == 3'd1);

    always_comb begin
        unique case (code[2:0])
            3'd0:    base = 1'b1;
            3'd1:    base = 1'b0;
            3'd2:    base = (d_cur == '0);
            3'd3:    base = df_cur;
            default: base = flags[fidx];
        endcase
    end

    // Bit 3 inverts the sense of the test; the reserved test is never met.
    assign taken = reserved ? 1'b0 : (base ^ code[3]);
endmodule

// File: rtl/accbr_pcstep.sv
module accbr_pcstep
    import accbr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] pc_lo,
    input  logic [DW-1:0] target,
    input  logic          load_target,
    input  logic          advance,
    output logic [DW-1:0] lo_nxt,
    output logic          hi_inc
);
    logic [DW:0] inc;

    assign inc = {1'b0, pc_lo} + {{DW{1'b0}}, 1'b1};

    always_comb begin
        if (load_target) begin
            lo_nxt = target;
            hi_inc = 1'b0;
        end else if (advance) begin
            lo_nxt = inc[DW-1:0];
            hi_inc = inc[DW];
        end else begin
            lo_nxt = pc_lo;
            hi_inc = 1'b0;
        end
    end
endmodule

// File: rtl/accbr_unit.sv
module accbr_unit
    import accbr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FN = FLAG_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_branch,
    input  logic [CODE_W-1:0] n_code,
    input  logic [DW-1:0]     opnd,
    input  logic [DW-1:0]     d_in,
    input  logic              df_in,
    input  logic [FN-1:0]     ext_flag,
    input  logic [DW-1:0]     pc_lo_in,
    output logic [DW-1:0]     d_out,
    output logic              df_out,
    output logic              br_taken,
    output logic [DW-1:0]     pc_lo_out,
    output logic              pc_hi_inc,
    output logic              imm_src
);
    alu_op_e       op;
    logic [DW-1:0] alu_d;
    logic          alu_df;
    logic          cond_ok;
    logic          take;
    logic          adv;
    logic [DW-1:0] pc_nxt;
    logic          pc_c;

    assign op   = alu_op_e'(n_code[2:0]);
    assign take = is_branch & cond_ok;
    assign adv  = is_branch | n_code[3];

    accbr_alu #(.DW(DW)) u_alu (
        .op(op), .opnd(opnd), .d_cur(d_in), .df_cur(df_in),
        .d_nxt(alu_d), .df_nxt(alu_df)
    );

    accbr_cond #(.DW(DW), .FN(FN)) u_cond (
        .code(n_code), .d_cur(d_in), .df_cur(df_in), .flags(ext_flag),
        .taken(cond_ok)
    );

    accbr_pcstep #(.DW(DW)) u_pc (
        .pc_lo(pc_lo_in), .target(opnd), .load_target(take), .advance(adv),
        .lo_nxt(pc_nxt), .hi_inc(pc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            d_out     <= '0;
            df_out    <= 1'b0;
            br_taken  <= 1'b0;
            pc_lo_out <= '0;
            pc_hi_inc <= 1'b0;
            imm_src   <= 1'b0;
        end else begin
            d_out     <= is_branch ? d_in  : alu_d;
            df_out    <= is_branch ? df_in : alu_df;
            br_taken  <= take;
            pc_lo_out <= pc_nxt;
            pc_hi_inc <= pc_c;
            imm_src   <= ~is_branch & n_code[3];
        end
    end

    // R2, R3: operations that are not add, subtract or shift keep the flag
    a_r3_flag_kept: assert property (@(posedge clk) disable iff (rst)
        (!is_branch && !writes_flag(alu_op_e'(n_code[2:0]))) |=> (df_out == $past(df_in)));

    // R6: shift clears the top bit and moves bit 0 into the flag
    a_r6_shift_out: assert property (@(posedge clk) disable iff (rst)
        (!is_branch && n_code[2:0] == 3'd6) |=> (!d_out[DW-1] && df_out == $past(d_in[0])));

    // R10: a branch leaves the accumulator and flag alone
    a_r10_branch_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        is_branch |=> (d_out == $past(d_in) && df_out == $past(df_in) && !imm_src));

    // R9: a taken branch loads the target and never carries
    a_r9_taken_target: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> !pc_hi_inc);

    // R7: ALU operations never report a branch
    a_r7_alu_no_branch: assert property (@(posedge clk) disable iff (rst)
        !is_branch |=> !br_taken);

    // R8: codes 1, 8 and 9 never branch
    a_r8_never_codes: assert property (@(posedge clk) disable iff (rst)
        (is_branch && (n_code == 4'd1 || n_code == 4'd8 || n_code == 4'd9)) |=> !br_taken);

    // R1: reset clears every output
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (d_out == '0 && !df_out && !br_taken && pc_lo_out == '0 && !pc_hi_inc && !imm_src));
endmodule

// File: tb/accbr_unit_test.sv
module accbr_unit_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       is_branch;
    logic [3:0] n_code;
    logic [7:0] opnd, d_in, pc_lo_in;
    logic       df_in;
    logic [3:0] ext_flag;
    logic [7:0] d_out, pc_lo_out;
    logic       df_out, br_taken, pc_hi_inc, imm_src;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    accbr_unit uut (
        .clk(clk), .rst(rst), .is_branch(is_branch), .n_code(n_code),
        .opnd(opnd), .d_in(d_in), .df_in(df_in), .ext_flag(ext_flag),
        .pc_lo_in(pc_lo_in), .d_out(d_out), .df_out(df_out),
        .br_taken(br_taken), .pc_lo_out(pc_lo_out), .pc_hi_inc(pc_hi_inc),
        .imm_src(imm_src)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, sample one nanosecond after the next rising edge.
    task automatic step(input logic br, input logic [3:0] n, input logic [7:0] o,
                        input logic [7:0] d, input logic f, input logic [3:0] fl,
                        input logic [7:0] pc);
        @(negedge clk);
        is_branch = br; n_code = n; opnd = o; d_in = d; df_in = f;
        ext_flag = fl; pc_lo_in = pc;
        @(posedge clk);
        #1;
    endtask

    task automatic alu_case(input string tag, input logic [3:0] n, input logic [7:0] o,
                            input logic [7:0] d, input logic f,
                            input logic [7:0] exp_d, input logic exp_f);
        step(1'b0, n, o, d, f, 4'h0, 8'h20);
        chk({tag, " d"}, d_out, exp_d);
        chk({tag, " df"}, df_out, exp_f);
        chk({tag, " taken"}, br_taken, 0);
    endtask

    task automatic br_case(input string tag, input logic [3:0] n, input logic [7:0] d,
                           input logic f, input logic [3:0] fl, input logic [7:0] pc,
                           input logic exp_t);
        logic [8:0] nx;
        nx = {1'b0, pc} + 9'd1;
        step(1'b1, n, 8'h5A, d, f, fl, pc);
        chk({tag, " taken"}, br_taken, exp_t);
        chk({tag, " pc_lo"}, pc_lo_out, exp_t ? 8'h5A : nx[7:0]);
        chk({tag, " hi_inc"}, pc_hi_inc, exp_t ? 0 : nx[8]);
        chk({tag, " d kept R10"}, d_out, d);
        chk({tag, " df kept R10"}, df_out, f);
        chk({tag, " imm R10"}, imm_src, 0);
    endtask

    task automatic t_reset();
        step(1'b1, 4'h0, 8'h77, 8'h99, 1'b1, 4'hF, 8'hFF);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 d", d_out, 0);
        chk("R1 df", df_out, 0);
        chk("R1 taken", br_taken, 0);
        chk("R1 pc", pc_lo_out, 0);
        chk("R1 hi", pc_hi_inc, 0);
        chk("R1 imm", imm_src, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_logic();
        alu_case("R2 load", 4'h0, 8'hA5, 8'h3C, 1'b1, 8'hA5, 1'b1);
        alu_case("R2 load df0", 4'h0, 8'h00, 8'hFF, 1'b0, 8'h00, 1'b0);
        alu_case("R3 or", 4'h1, 8'hA0, 8'h0C, 1'b1, 8'hAC, 1'b1);
        alu_case("R3 and", 4'h2, 8'hF0, 8'h3C, 1'b0, 8'h30, 1'b0);
        alu_case("R3 xor", 4'h3, 8'hFF, 8'h3C, 1'b1, 8'hC3, 1'b1);
    endtask

    task automatic t_add();
        alu_case("R4 add carry", 4'h4, 8'h50, 8'hC8, 1'b0, 8'h18, 1'b1);
        alu_case("R4 add no carry", 4'h4, 8'h12, 8'h34, 1'b1, 8'h46, 1'b0);
    endtask

    task automatic t_sub();
        alu_case("R5 m-d no borrow", 4'h5, 8'h30, 8'h10, 1'b0, 8'h20, 1'b1);
        alu_case("R5 m-d borrow", 4'h5, 8'h10, 8'h30, 1'b1, 8'hE0, 1'b0);
        alu_case("R5 d-m borrow", 4'h7, 8'h30, 8'h10, 1'b1, 8'hE0, 1'b0);
        alu_case("R5 d-m no borrow", 4'h7, 8'h10, 8'h30, 1'b0, 8'h20, 1'b1);
        alu_case("R5 equal", 4'h7, 8'h44, 8'h44, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic t_shift();
        alu_case("R6 shr odd", 4'h6, 8'hFF, 8'h81, 1'b0, 8'h40, 1'b1);
        alu_case("R6 shr even", 4'h6, 8'h00, 8'hFE, 1'b1, 8'h7F, 1'b0);
    endtask

    task automatic t_imm();
        step(1'b0, 4'hC, 8'h01, 8'h01, 1'b0, 4'h0, 8'h10);
        chk("R7 imm add d", d_out, 8'h02);
        chk("R7 imm flag", imm_src, 1);
        chk("R7 imm pc", pc_lo_out, 8'h11);
        chk("R7 imm hi", pc_hi_inc, 0);
        step(1'b0, 4'h8, 8'h9E, 8'h00, 1'b1, 4'h0, 8'hFF);
        chk("R7 imm wrap pc", pc_lo_out, 8'h00);
        chk("R7 imm wrap hi", pc_hi_inc, 1);
        chk("R7 imm load d", d_out, 8'h9E);
        step(1'b0, 4'h0, 8'h9E, 8'h00, 1'b1, 4'h0, 8'hFF);
        chk("R7 mem flag", imm_src, 0);
        chk("R7 mem pc", pc_lo_out, 8'hFF);
        chk("R7 mem hi", pc_hi_inc, 0);
    endtask

    task automatic t_branch();
        br_case("R8 always", 4'h0, 8'h11, 1'b0, 4'h0, 8'h40, 1'b1);
        br_case("R8 never8", 4'h8, 8'h11, 1'b0, 4'h0, 8'h40, 1'b0);
        br_case("R8 code1", 4'h1, 8'h00, 1'b1, 4'hF, 8'h40, 1'b0);
        br_case("R8 code9", 4'h9, 8'h00, 1'b1, 4'hF, 8'h40, 1'b0);
        br_case("R8 dzero hit", 4'h2, 8'h00, 1'b0, 4'h0, 8'h40, 1'b1);
        br_case("R8 dzero miss", 4'h2, 8'h01, 1'b0, 4'h0, 8'h40, 1'b0);
        br_case("R8 dnz hit", 4'hA, 8'h80, 1'b0, 4'h0, 8'h40, 1'b1);
        br_case("R8 dnz miss", 4'hA, 8'h00, 1'b1, 4'h0, 8'h40, 1'b0);
        br_case("R8 df set", 4'h3, 8'h11, 1'b1, 4'h0, 8'h40, 1'b1);
        br_case("R8 df clr", 4'hB, 8'h11, 1'b1, 4'h0, 8'h40, 1'b0);
        for (int i = 0; i < 4; i++) begin
            br_case("R8 flag high hit", 4'(4 + i), 8'h11, 1'b0, 4'(1 << i), 8'h40, 1'b1);
            br_case("R8 flag high miss", 4'(4 + i), 8'h11, 1'b0, ~4'(1 << i), 8'h40, 1'b0);
            br_case("R8 flag low hit", 4'(12 + i), 8'h11, 1'b0, ~4'(1 << i), 8'h40, 1'b1);
        end
        br_case("R9 miss wrap", 4'h8, 8'h11, 1'b0, 4'h0, 8'hFF, 1'b0);
        br_case("R9 hit at FF", 4'h0, 8'h11, 1'b0, 4'h0, 8'hFF, 1'b1);
    endtask

    task automatic t_latency();
        step(1'b0, 4'h0, 8'h3E, 8'h00, 1'b0, 4'h0, 8'h00);
        @(negedge clk);
        opnd = 8'hC1;
        #1;
        chk("R11 holds between edges", d_out, 8'h3E);
        @(posedge clk); #1;
        chk("R11 next edge", d_out, 8'hC1);
    endtask

    initial begin
        rst = 1'b1; is_branch = 0; n_code = 0; opnd = 0; d_in = 0;
        df_in = 0; ext_flag = 0; pc_lo_in = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 initial d", d_out, 0);
        chk("R1 initial pc", pc_lo_out, 0);
        @(negedge clk); rst = 1'b0;
        t_logic();
        t_add();
        t_sub();
        t_shift();
        t_imm();
        t_branch();
        t_latency();
        t_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule